// File: doc/BRIEF.md
# Multi-Burst CRC Integrity Checker

This block sits on the receiving side of a DMA data path. A command moves its data in one or more bursts. During each burst the block folds every received 16-bit word into a running CRC. When the burst closes, the sender supplies its own CRC word, and the block compares that word with its local value. A difference marks the burst as failed.

Failures are not reported while the command is still running. The block remembers only the earliest failing burst of the command, and it gives its position within the command. When the command ends, the block raises a one-cycle completion pulse. In that same cycle it publishes the error verdict and the burst index. These reported values stay readable until the next command begins.

Top module: `burst_crc_checker`

## Requirements
- R1: The running CRC uses generator polynomial 16'h1021 (x^16+x^12+x^5+1), with no reflection and no final inversion. Each accepted word is folded in during one clock, bit 15 first. Two CRC results are equal only when all 16 bits match.
- R2: A burst_start pulse loads the running CRC with 16'h4ABA. A burst that contains no words is therefore compared against 16'h4ABA.
- R3: A burst_end pulse compares host_crc with the CRC of the words accepted in the earlier cycles of that burst. word_valid is ignored in any cycle where burst_start or burst_end is high.
- R4: err_flag and err_burst_idx change only in the cycle after a cmd_end pulse or a cmd_start pulse. A failed burst in the middle of a command leaves them unchanged.
- R5: err_burst_idx gives the 0-based position of the first failing burst counted from cmd_start. Later mismatches in the same command change neither the flag nor the index.
- R6: done_pulse is high for exactly the one cycle after a cmd_end pulse. err_flag and err_burst_idx are valid in that cycle and hold until the next cmd_end or cmd_start. A burst_end in the same cycle as cmd_end is included in the report.
- R7: A cmd_start pulse clears the first-error latch, the burst counter and the reported outputs. It takes priority over cmd_end in the same cycle, and in that case no done_pulse is produced.
- R8: The burst counter saturates at 2^IDX_W-1, so a first failure at or after that position reports index 2^IDX_W-1.
- R9: After reset, err_flag, err_burst_idx and done_pulse are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Pulse that opens a new command |
| cmd_end | input | 1 | Pulse that closes the current command |
| burst_start | input | 1 | Pulse that opens a burst and loads the CRC seed |
| word_valid | input | 1 | word_data carries a received data word |
| word_data | input | 16 | Received data word |
| burst_end | input | 1 | Pulse that closes the burst; host_crc is valid |
| host_crc | input | 16 | CRC word sent by the host |
| err_flag | output | 1 | Command had at least one failing burst |
| err_burst_idx | output | IDX_W | Position of the first failing burst |
| done_pulse | output | 1 | One-cycle pulse after cmd_end |

## Verification
A wrong running CRC does not appear at the ports while the command is active. It first becomes visible as a wrong err_flag in the done_pulse cycle of that command, one cycle after cmd_end. A first-error latch that is overwritten, or a burst counter that is off by one, shows the same way: a wrong err_burst_idx at command completion. A latch or counter that fails to clear is seen only at the end of the following command. For that reason the bench runs commands back to back, alternating good and bad ones, and checks the report of every command at its done pulse.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
    localparam int          CRC_W       = 16;
    localparam logic [15:0] CRC_POLY    = 16'h1021;
    localparam logic [15:0] CRC_SEED    = 16'h4ABA;
    localparam int          DEF_IDX_W   = 4;
endpackage

// File: rtl/bcc_crc_step.sv
// Folds one full data word into a CRC register in one combinational step.
module bcc_crc_step #(
    parameter int          W    = 16,
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] crc_out
);
    // Chain of W single-bit stages, most significant data bit first.
    logic [W-1:0] stage [W+1];

    assign stage[0] = crc_in;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic fb;
        assign fb          = stage[i][W-1] ^ data_in[W-1-i];
        assign stage[i+1]  = {stage[i][W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
    end

    assign crc_out = stage[W];
endmodule

// File: rtl/bcc_burst_accum.sv
// Per-burst CRC accumulator and end-of-burst comparator.
module bcc_burst_accum #(
    parameter int          W    = 16,
    parameter logic [15:0] SEED = 16'h4ABA,
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         burst_start,
    input  logic         burst_end,
    input  logic         word_valid,
    input  logic [W-1:0] word_data,
    input  logic [W-1:0] host_crc,
    output logic [W-1:0] crc_o,
    output logic         closed_o,
    output logic         mismatch_o
);
    typedef struct packed {
        logic [W-1:0] crc;
    } acc_t;

    acc_t         st_d, st_q;
    logic [W-1:0] crc_next_word;

    bcc_crc_step #(.W(W), .POLY(POLY)) u_step (
        .crc_in  (st_q.crc),
        .data_in (word_data),
        .crc_out (crc_next_word)
    );

    always_comb begin
        st_d = st_q;
        if (burst_start) begin
            st_d.crc = SEED[W-1:0];
        end else if (word_valid && !burst_end) begin
            st_d.crc = crc_next_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.crc <= SEED[W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    // A burst_end that collides with burst_start is dropped: the new burst wins.
    assign closed_o   = burst_end && !burst_start;
    assign mismatch_o = closed_o && (host_crc != st_q.crc);
    assign crc_o      = st_q.crc;
endmodule

// File: rtl/bcc_first_fail.sv
// Burst counter and first-failure latch for one command.
module bcc_first_fail #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             burst_closed,
    input  logic             burst_bad,
    output logic             err_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             err_next_o,
    output logic [IDX_W-1:0] idx_next_o
);
    localparam logic [IDX_W-1:0] CNT_MAX = {IDX_W{1'b1}};

    typedef struct packed {
        logic [IDX_W-1:0] cnt;
        logic             err;
        logic [IDX_W-1:0] idx;
    } ff_t;

    ff_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_start) begin
            st_d = '0;
        end else if (burst_closed) begin
            if (burst_bad && !st_q.err) begin
                st_d.err = 1'b1;
                st_d.idx = st_q.cnt;
            end
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o      = st_q.err;
    assign idx_o      = st_q.idx;
    assign err_next_o = st_d.err;
    assign idx_next_o = st_d.idx;
endmodule

// File: rtl/burst_crc_checker.sv
// Top: CRC accumulation per burst, first-failure latch per command,
// report registers updated only at command end.
module burst_crc_checker
    import bcc_pkg::*;
#(
    parameter int IDX_W = DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_end,
    input  logic             burst_start,
    input  logic             word_valid,
    input  logic [15:0]      word_data,
    input  logic             burst_end,
    input  logic [15:0]      host_crc,
    output logic             err_flag,
    output logic [IDX_W-1:0] err_burst_idx,
    output logic             done_pulse
);
    typedef struct packed {
        logic             done;
        logic             err;
        logic [IDX_W-1:0] idx;
    } rep_t;

    logic [CRC_W-1:0] acc_crc;
    logic             acc_closed;
    logic             acc_bad;
    logic             lat_err;
    logic [IDX_W-1:0] lat_idx;
    logic             lat_err_next;
    logic [IDX_W-1:0] lat_idx_next;

    rep_t rep_d, rep_q;

    bcc_burst_accum #(.W(CRC_W), .SEED(CRC_SEED), .POLY(CRC_POLY)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_start (burst_start),
        .burst_end   (burst_end),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .host_crc    (host_crc),
        .crc_o       (acc_crc),
        .closed_o    (acc_closed),
        .mismatch_o  (acc_bad)
    );

    bcc_first_fail #(.IDX_W(IDX_W)) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .burst_closed (acc_closed),
        .burst_bad    (acc_bad),
        .err_o        (lat_err),
        .idx_o        (lat_idx),
        .err_next_o   (lat_err_next),
        .idx_next_o   (lat_idx_next)
    );

    always_comb begin
        rep_d      = rep_q;
        rep_d.done = 1'b0;
        if (cmd_start) begin
            rep_d = '0;
        end else if (cmd_end) begin
            rep_d.done = 1'b1;
            rep_d.err  = lat_err_next;
            rep_d.idx  = lat_idx_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q <= '0;
        end else begin
            rep_q <= rep_d;
        end
    end

    assign err_flag      = rep_q.err;
    assign err_burst_idx = rep_q.idx;
    assign done_pulse    = rep_q.done;
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker
    import bcc_pkg::*;
#(
    parameter int IDX_W = DEF_IDX_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start,
    input logic             cmd_end,
    input logic             burst_start,
    input logic             err_flag,
    input logic [IDX_W-1:0] err_burst_idx,
    input logic             done_pulse,
    input logic [15:0]      acc_crc,
    input logic             lat_err,
    input logic [IDX_W-1:0] lat_idx
);
    // R2
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> acc_crc == CRC_SEED);

    // R4
    report_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_end && !cmd_start) |=> ($stable(err_flag) && $stable(err_burst_idx)));

    // R5
    latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_err && !cmd_start) |=> (lat_err && $stable(lat_idx)));

    // R6
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> ($past(cmd_end) && !$past(cmd_start)));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (!err_flag && err_burst_idx == '0 && !done_pulse && !lat_err));
endmodule

bind burst_crc_checker bcc_checker #(.IDX_W(IDX_W)) u_bcc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_start     (cmd_start),
    .cmd_end       (cmd_end),
    .burst_start   (burst_start),
    .err_flag      (err_flag),
    .err_burst_idx (err_burst_idx),
    .done_pulse    (done_pulse),
    .acc_crc       (acc_crc),
    .lat_err       (lat_err),
    .lat_idx       (lat_idx)
);

// File: tb/burst_crc_checker_tb.sv
module burst_crc_checker_tb_top;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_start = 1'b0, cmd_end = 1'b0;
    logic             burst_start = 1'b0, word_valid = 1'b0, burst_end = 1'b0;
    logic [15:0]      word_data = '0, host_crc = '0;
    logic             err_flag, done_pulse;
    logic [IDX_W-1:0] err_burst_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    burst_crc_checker #(.IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_end(cmd_end),
        .burst_start(burst_start), .word_valid(word_valid), .word_data(word_data),
        .burst_end(burst_end), .host_crc(host_crc), .err_flag(err_flag),
        .err_burst_idx(err_burst_idx), .done_pulse(done_pulse)
    );

    typedef struct packed {
        logic [4:0]  nb;
        logic [15:0] bad;
        logic        exp_err;
        logic [3:0]  exp_idx;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{nb: 5'd3, bad: 16'h0000, exp_err: 1'b0, exp_idx: 4'd0},
        '{nb: 5'd3, bad: 16'h0002, exp_err: 1'b1, exp_idx: 4'd1},
        '{nb: 5'd4, bad: 16'h0009, exp_err: 1'b1, exp_idx: 4'd0},
        '{nb: 5'd5, bad: 16'h0018, exp_err: 1'b1, exp_idx: 4'd3},
        '{nb: 5'd1, bad: 16'h0000, exp_err: 1'b0, exp_idx: 4'd0},
        '{nb: 5'd2, bad: 16'h0002, exp_err: 1'b1, exp_idx: 4'd1}
    };

    // Reference CRC: whole-word xor, then 16 shifts of the generator.
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
        logic [15:0] r;
        r = c ^ d;
        for (int k = 0; k < 16; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_cmd_start();
        @(negedge clk) cmd_start = 1'b1;
        @(negedge clk) cmd_start = 1'b0;
    endtask

    // One burst: nw words, corrupted host CRC if bad, optional junk word in the end cycle.
    task automatic send_burst(input int nw, input int salt, input bit bad, input bit junk_at_end);
        logic [15:0] m;
        m = 16'h4ABA;
        @(negedge clk) burst_start = 1'b1;
        @(negedge clk) burst_start = 1'b0;
        for (int w = 0; w < nw; w++) begin
            word_valid = 1'b1;
            word_data  = 16'hA5C3 ^ 16'(salt * 16'h1357) ^ 16'(w * 16'h0F1E);
            m = ref_crc(m, word_data);
            @(negedge clk);
        end
        word_valid = junk_at_end;
        word_data  = 16'hDEAD;
        burst_end  = 1'b1;
        host_crc   = bad ? (m ^ 16'h0100) : m;
        @(negedge clk);
        burst_end  = 1'b0;
        word_valid = 1'b0;
    endtask

    task automatic end_cmd_check(input bit e_err, input int e_idx, input string req);
        @(negedge clk) cmd_end = 1'b1;
        @(negedge clk) cmd_end = 1'b0;
        check(done_pulse == 1'b1, {req, " R6 done"}, done_pulse, 1);
        check(err_flag == e_err, {req, " err_flag"}, err_flag, e_err);
        check(int'(err_burst_idx) == e_idx, {req, " idx"}, err_burst_idx, e_idx);
        @(negedge clk);
        check(done_pulse == 1'b0, "R6 done one cycle", done_pulse, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(err_flag == 0 && done_pulse == 0 && err_burst_idx == 0, "R9 reset", {err_flag, done_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R3 R5 R6
        for (int v = 0; v < NV; v++) begin
            pulse_cmd_start();
            check(err_flag == 0, "R7 cleared at start", err_flag, 0);
            for (int b = 0; b < int'(VECS[v].nb); b++) begin
                send_burst((b % 4) + 1, v * 7 + b, VECS[v].bad[b], 1'b0);
                check(err_flag == 0 && done_pulse == 0, "R4 no early report", err_flag, 0);
            end
            end_cmd_check(VECS[v].exp_err, int'(VECS[v].exp_idx), "R1 R5 table");
            check(err_flag == VECS[v].exp_err, "R6 report held", err_flag, VECS[v].exp_err);
        end

        // R2 empty burst against the seed, then a wrong seed
        pulse_cmd_start();
        send_burst(0, 0, 1'b0, 1'b0);
        end_cmd_check(1'b0, 0, "R2 empty good");
        pulse_cmd_start();
        send_burst(0, 0, 1'b0, 1'b0);
        send_burst(0, 0, 1'b1, 1'b0);
        end_cmd_check(1'b1, 1, "R2 empty bad");

        // R3 word in the burst_end cycle is ignored
        pulse_cmd_start();
        send_burst(2, 9, 1'b0, 1'b1);
        end_cmd_check(1'b0, 0, "R3 end-cycle word");

        // R8 first failure beyond counter range saturates
        pulse_cmd_start();
        for (int b = 0; b < 18; b++) send_burst(1, b, b == 17, 1'b0);
        end_cmd_check(1'b1, 15, "R8 saturate");

        // R7 cmd_start mid-command clears the latch
        pulse_cmd_start();
        send_burst(1, 3, 1'b1, 1'b0);
        pulse_cmd_start();
        send_burst(1, 4, 1'b0, 1'b0);
        end_cmd_check(1'b0, 0, "R7 mid clear");

        // R6 burst_end in the same cycle as cmd_end is included
        pulse_cmd_start();
        send_burst(1, 5, 1'b0, 1'b0);
        @(negedge clk) burst_start = 1'b1;
        @(negedge clk) burst_start = 1'b0;
        burst_end = 1'b1; cmd_end = 1'b1; host_crc = 16'h4ABA ^ 16'h0001;
        @(negedge clk) burst_end = 1'b0; cmd_end = 1'b0;
        check(done_pulse && err_flag && err_burst_idx == 1, "R6 same-cycle end", {err_flag, err_burst_idx}, 'h11);

        // R7 cmd_start beats cmd_end: report cleared, no done
        @(negedge clk) cmd_start = 1'b1; cmd_end = 1'b1;
        @(negedge clk) cmd_start = 1'b0; cmd_end = 1'b0;
        check(!done_pulse && !err_flag, "R7 start priority", {done_pulse, err_flag}, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule